// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block turns a wide vector of general-purpose input pins into per-bank interrupt requests. Pins are grouped into ports of eight. Each bank contains a fixed number of ports, four by default. For every pin the block keeps a trigger configuration, an enable bit and a latched status bit. Each pin can be set to one of five event types: active-low level, active-high level, rising edge, falling edge, or both edges. The pin inputs first pass through a two-flop synchronizer. Detection works only on the synchronized samples.

Software controls the block through a plain 32-bit register port with a select, a write strobe and an address. Read data is combinational from the addressed register. A register can be read or written in a single cycle. Status is cleared by writing ones to a clear register. Single enable bits can be changed through a masked-write alias, so software needs no read-modify-write. Each bank drives its own interrupt line. The line is high while any pin in that bank has both its status bit and its enable bit set.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset every enable bit and every trigger field is 0, so each pin is a disabled active-low level source, and all bank interrupt lines are low.
- R2: Address bits [11:8] select the bank and bits [3:2] select the port within it. Bits [7:4] select the register group: 0x4 status (read only), 0x5 enable, 0x6 trigger, 0x7 clear (write only, reads 0), 0xD masked enable. An address in a bank at or above NUM_BANKS reads 0 and ignores writes.
- R3: For pin j of a port, the trigger register holds the polarity bit at j, the edge bit at 8+j and the both-edges bit at 16+j. Bits [31:24] always read 0.
- R4: With the edge bit 0, the status bit follows the synchronized pin level. The pin is active when it equals the polarity bit. A change at the pin shows up in status on the third rising clock edge after it.
- R5: Polarity 1 with edge 1 detects rising edges. Polarity 0 with edge 1 detects falling edges. A detected edge sets status, which then holds until cleared, and the opposite edge leaves it unchanged.
- R6: With the edge bit and the both-edges bit set, either transition of the pin sets status.
- R7: Writing 1 to a bit of the clear register clears that status bit. Writing 0 leaves it unchanged. In level mode, if the level is still active, the bit sets again one cycle after the clear.
- R8: In edge modes, if an edge is detected in the same cycle that a clear is written, status stays set.
- R9: A write to the enable register loads bits [7:0]. A write to the masked alias changes only the pins whose bit in [15:8] is 1, loading them from [7:0]. The alias reads back the enables.
- R10: Each bank's interrupt line is the OR, over all pins of that bank's ports, of status AND enable. The banks are independent of each other.
- R11: A status read returns the latched status whether or not the pins are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | NUM_BANKS*PORTS_PER_BANK*8 | Raw pin inputs, may be asynchronous |
| bank_irq | output | NUM_BANKS | One interrupt line per bank |

## Verification
The assertions assume that bus_sel, bus_we, bus_addr and bus_wdata are synchronous to clk and stay steady for a whole cycle. The pins may change at any time, and the level check relies on the synchronizer stage that sits between them and detection. The bench drives both the bus and the pins only just after a falling edge, and each write is held for exactly one rising edge. Every read is sampled mid-cycle, so a status change is observed only after the three-edge path from the pin has completed. The same-cycle edge and clear case is lined up by counting rising edges from the pin change.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and types for the banked GPIO interrupt controller.
// Assumes eight pins per port; the trigger layout depends on that width.
package gpio_irq_pkg;

    localparam int PORT_PINS = 8;

    // Register group codes carried in address bits [7:4]
    typedef enum logic [3:0] {
        GRP_STATUS  = 4'h4,
        GRP_ENABLE  = 4'h5,
        GRP_TRIGGER = 4'h6,
        GRP_CLEAR   = 4'h7,
        GRP_EN_MASK = 4'hD
    } grp_e;

    // Trigger configuration of one port: one byte lane per attribute
    typedef struct packed {
        logic [PORT_PINS-1:0] both;
        logic [PORT_PINS-1:0] edg;
        logic [PORT_PINS-1:0] high;
    } trig_cfg_t;

endpackage

// File: rtl/gpio_irq_sync.sv
// Two-flop synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_irq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    // Two register stages bring the pins into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
// One 8-pin port: trigger config, enables, event detection and status.
// Assumes pin_s is already synchronized and at most one write strobe is
// active per cycle (guaranteed by the single address decode above it).
module gpio_irq_port
    import gpio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_PINS-1:0] pin_s,
    input  logic                 wr_en,
    input  logic                 wr_en_msk,
    input  logic                 wr_cfg,
    input  logic                 wr_clr,
    input  logic [23:0]          wdata,
    output logic [PORT_PINS-1:0] status,
    output logic [PORT_PINS-1:0] enable,
    output trig_cfg_t            cfg,
    output logic                 irq
);

    logic [PORT_PINS-1:0] prev;
    logic [PORT_PINS-1:0] rise, fall, edge_hit, lvl_act, clr_bits, status_nxt;
    logic [PORT_PINS-1:0] msk_sel, msk_val;

    assign msk_sel = wdata[15:8];
    assign msk_val = wdata[7:0];

    // Keep the previous synchronized sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= pin_s;
    end

    // Classify events per pin and form the next status value
    always_comb begin
        rise       = pin_s & ~prev;
        fall       = ~pin_s & prev;
        lvl_act    = ~(pin_s ^ cfg.high);
        edge_hit   = (cfg.both & (rise | fall))
                   | (~cfg.both & ((cfg.high & rise) | (~cfg.high & fall)));
        clr_bits   = wr_clr ? wdata[7:0] : '0;
        status_nxt = (cfg.edg & (edge_hit | (status & ~clr_bits)))
                   | (~cfg.edg & lvl_act & ~clr_bits);
    end

    // Latch status every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_nxt;
    end

    // Enable register with direct and masked write paths
    always_ff @(posedge clk) begin
        if (!rst_n)         enable <= '0;
        else if (wr_en)     enable <= wdata[7:0];
        else if (wr_en_msk) enable <= (enable & ~msk_sel) | (msk_val & msk_sel);
    end

    // Trigger configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (wr_cfg) cfg <= wdata;
    end

    assign irq = |(status & enable);

    genvar j;
    generate
        for (j = 0; j < PORT_PINS; j++) begin : g_chk
            // R9
            en_mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en_msk && !wdata[8+j]) |=> (enable[j] == $past(enable[j])));
            // R5
            edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg.edg[j] && status[j] && !(wr_clr && wdata[j]) && !wr_cfg) |=> status[j]);
            // R7
            lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg.edg[j] && wr_clr && wdata[j] && !wr_cfg) |=> !status[j]);
            // R4
            lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg.edg[j] && !wr_cfg && !(wr_clr && wdata[j]))
                |=> (status[j] == ($past(pin_s[j]) == $past(cfg.high[j]))));
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Banked GPIO interrupt controller top: register decode, read mux,
// per-port detection instances and per-bank interrupt reduction.
// Assumes bus signals are synchronous to clk; pins may be asynchronous.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS      = 2,
    parameter int PORTS_PER_BANK = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          bus_sel,
    input  logic                                          bus_we,
    input  logic [11:0]                                   bus_addr,
    input  logic [31:0]                                   bus_wdata,
    output logic [31:0]                                   bus_rdata,
    input  logic [NUM_BANKS*PORTS_PER_BANK*PORT_PINS-1:0] pin_in,
    output logic [NUM_BANKS-1:0]                          bank_irq
);

    localparam int NPORTS   = NUM_BANKS * PORTS_PER_BANK;
    localparam int NUM_PINS = NPORTS * PORT_PINS;
    localparam int PORT_AW  = $clog2(PORTS_PER_BANK);
    localparam int IDX_W    = $clog2(NPORTS);

    logic [NUM_PINS-1:0]  pin_s;
    logic [3:0]           a_bank;
    logic [3:0]           a_grp;
    logic [PORT_AW-1:0]   a_port;
    logic                 bank_ok;
    logic [IDX_W-1:0]     idx;
    logic                 bus_wr;
    logic [PORT_PINS-1:0] st_arr [NPORTS];
    logic [PORT_PINS-1:0] en_arr [NPORTS];
    trig_cfg_t            cfg_arr[NPORTS];
    logic [NPORTS-1:0]    port_irq;
    logic                 unused_bits;

    assign a_bank      = bus_addr[11:8];
    assign a_grp       = bus_addr[7:4];
    assign a_port      = bus_addr[2 +: PORT_AW];
    assign bank_ok     = (int'(a_bank) < NUM_BANKS);
    assign idx         = IDX_W'(a_bank) * IDX_W'(PORTS_PER_BANK) + IDX_W'(a_port);
    assign bus_wr      = bus_sel && bus_we && bank_ok;
    assign unused_bits = ^{bus_wdata[31:24], bus_addr[1:0]};

    gpio_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    genvar k;
    generate
        for (k = 0; k < NPORTS; k++) begin : g_port
            localparam int B = k / PORTS_PER_BANK;
            localparam int P = k % PORTS_PER_BANK;
            logic hit;
            assign hit = bus_wr && (a_bank == 4'(B)) && (a_port == PORT_AW'(P));

            gpio_irq_port u_port (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_s     (pin_s[k*PORT_PINS +: PORT_PINS]),
                .wr_en     (hit && (a_grp == GRP_ENABLE)),
                .wr_en_msk (hit && (a_grp == GRP_EN_MASK)),
                .wr_cfg    (hit && (a_grp == GRP_TRIGGER)),
                .wr_clr    (hit && (a_grp == GRP_CLEAR)),
                .wdata     (bus_wdata[23:0]),
                .status    (st_arr[k]),
                .enable    (en_arr[k]),
                .cfg       (cfg_arr[k]),
                .irq       (port_irq[k])
            );
        end
    endgenerate

    // Select read data for the addressed port and register group
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && bank_ok) begin
            case (a_grp)
                GRP_STATUS:  bus_rdata = {24'h0, st_arr[idx]};
                GRP_ENABLE:  bus_rdata = {24'h0, en_arr[idx]};
                GRP_EN_MASK: bus_rdata = {24'h0, en_arr[idx]};
                GRP_TRIGGER: bus_rdata = {8'h0, cfg_arr[idx]};
                default:     bus_rdata = '0;
            endcase
        end
    end

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic [PORTS_PER_BANK*PORT_PINS-1:0] bank_en;

            assign bank_irq[b] = |port_irq[b*PORTS_PER_BANK +: PORTS_PER_BANK];

            // Gather the bank's enables for the checker below
            always_comb begin
                for (int p = 0; p < PORTS_PER_BANK; p++)
                    bank_en[p*PORT_PINS +: PORT_PINS] = en_arr[b*PORTS_PER_BANK + p];
            end

            // R10
            bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_en == '0) |-> !bank_irq[b]);
        end
    endgenerate

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
// Directed bench for the banked GPIO interrupt controller.
module gpio_irq_ctrl_tb;

    localparam int NB  = 2;
    localparam int PPB = 4;
    localparam int NP  = NB * PPB * 8;
    localparam int WD  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pins = '1;
    logic [NB-1:0] bank_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_cnt = 0;
    bit done    = 1'b0;

    gpio_irq_ctrl #(.NUM_BANKS(NB), .PORTS_PER_BANK(PPB)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pins),
        .bank_irq  (bank_irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc_cnt = cyc_cnt + 1;
        if (cyc_cnt == WD && !done) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [11:0] ra(input int bk, input int grp, input int pt);
        return {bk[3:0], grp[3:0], pt[1:0], 2'b00};
    endfunction

    function automatic int pin(input int bk, input int pt, input int j);
        return bk * PPB * 8 + pt * 8 + j;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] addr, input logic [31:0] exp, input string tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = addr;
        #1;
        chk(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic irq_chk(input logic [NB-1:0] exp, input string tag);
        #1;
        chk(tag, {{(32-NB){1'b0}}, bank_irq}, {{(32-NB){1'b0}}, exp});
    endtask

    task automatic t_reset();
        rd_chk(ra(0, 5, 0), 32'h0, "R1 enable after reset");
        rd_chk(ra(1, 6, 3), 32'h0, "R1 trigger after reset");
        irq_chk(2'b00, "R1 irq after reset");
        rd_chk(ra(0, 4, 0), 32'h0, "R4 active-low idle high pins");
    endtask

    task automatic t_level();
        wr(ra(0, 6, 1), 32'h0000_0008);
        cyc(2);
        rd_chk(ra(0, 4, 1), 32'h08, "R4 active-high pin high");
        pins[pin(0, 1, 3)] = 1'b0;
        cyc(2);
        rd_chk(ra(0, 4, 1), 32'h08, "R4 latency two edges");
        cyc(1);
        rd_chk(ra(0, 4, 1), 32'h00, "R4 latency third edge");
        pins[pin(0, 1, 5)] = 1'b0;
        cyc(3);
        rd_chk(ra(0, 4, 1), 32'h20, "R4 active-low pin low");
        irq_chk(2'b00, "R10 disabled pin no irq");
        wr(ra(0, 5, 1), 32'h0000_0020);
        irq_chk(2'b01, "R10 bank0 irq");
    endtask

    task automatic t_clear_level();
        wr(ra(0, 7, 1), 32'h0000_0020);
        rd_chk(ra(0, 4, 1), 32'h00, "R7 level clear");
        irq_chk(2'b00, "R7 irq drops on clear");
        cyc(1);
        rd_chk(ra(0, 4, 1), 32'h20, "R7 level sets again");
        pins[pin(0, 1, 5)] = 1'b1;
        wr(ra(0, 5, 1), 32'h0);
        cyc(3);
        irq_chk(2'b00, "R10 bank0 quiet");
    endtask

    task automatic t_edges();
        wr(ra(1, 6, 2), 32'hFF04_0701);
        rd_chk(ra(1, 6, 2), 32'h0004_0701, "R3 trigger layout readback");
        rd_chk(ra(1, 4, 2), 32'h00, "R5 no event yet");
        pins[pin(1, 2, 0)] = 1'b0;
        cyc(3);
        rd_chk(ra(1, 4, 2), 32'h00, "R5 rising ignores fall");
        pins[pin(1, 2, 0)] = 1'b1;
        cyc(3);
        rd_chk(ra(1, 4, 2), 32'h01, "R5 rising edge sets");
        pins[pin(1, 2, 0)] = 1'b0;
        cyc(3);
        rd_chk(ra(1, 4, 2), 32'h01, "R5 sticky status");
        wr(ra(1, 7, 2), 32'h0000_0000);
        rd_chk(ra(1, 4, 2), 32'h01, "R7 zero write no effect");
        wr(ra(1, 7, 2), 32'h0000_0001);
        rd_chk(ra(1, 4, 2), 32'h00, "R7 edge clear");
        pins[pin(1, 2, 1)] = 1'b0;
        cyc(3);
        rd_chk(ra(1, 4, 2), 32'h02, "R5 falling edge sets");
        wr(ra(1, 7, 2), 32'h0000_0002);
        pins[pin(1, 2, 1)] = 1'b1;
        cyc(3);
        rd_chk(ra(1, 4, 2), 32'h00, "R5 falling ignores rise");
        pins[pin(1, 2, 2)] = 1'b0;
        cyc(3);
        rd_chk(ra(1, 4, 2), 32'h04, "R6 both edges fall");
        wr(ra(1, 7, 2), 32'h0000_0004);
        rd_chk(ra(1, 4, 2), 32'h00, "R6 cleared");
        pins[pin(1, 2, 2)] = 1'b1;
        cyc(3);
        rd_chk(ra(1, 4, 2), 32'h04, "R6 both edges rise");
    endtask

    task automatic t_edge_vs_clear();
        @(negedge clk);
        pins[pin(1, 2, 2)] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        wr(ra(1, 7, 2), 32'h0000_0004);
        rd_chk(ra(1, 4, 2), 32'h04, "R8 edge wins over clear");
        wr(ra(1, 7, 2), 32'h0000_0004);
        rd_chk(ra(1, 4, 2), 32'h00, "R8 clear without edge");
    endtask

    task automatic t_mask();
        wr(ra(1, 5, 2), 32'h0000_000F);
        rd_chk(ra(1, 5, 2), 32'h0F, "R9 direct enable");
        wr(ra(1, 13, 2), 32'h0000_3010);
        rd_chk(ra(1, 5, 2), 32'h1F, "R9 masked set");
        wr(ra(1, 13, 2), 32'h0000_0100);
        rd_chk(ra(1, 5, 2), 32'h1E, "R9 masked clear keeps others");
        rd_chk(ra(1, 13, 2), 32'h1E, "R9 alias readback");
    endtask

    task automatic t_irq();
        pins[pin(1, 2, 2)] = 1'b1;
        cyc(3);
        irq_chk(2'b10, "R10 bank1 irq");
        wr(ra(1, 13, 2), 32'h0000_0400);
        irq_chk(2'b00, "R10 disable drops irq");
        rd_chk(ra(1, 4, 2), 32'h04, "R11 status without enable");
    endtask

    task automatic t_unmapped();
        wr(ra(2, 5, 0), 32'h0000_00FF);
        rd_chk(ra(0, 5, 0), 32'h00, "R2 unmapped write ignored");
        rd_chk(ra(2, 5, 0), 32'h00, "R2 unmapped read zero");
        rd_chk(ra(1, 7, 2), 32'h00, "R2 clear reads zero");
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(5);
        t_reset();
        t_level();
        t_clear_level();
        t_edges();
        t_edge_vs_clear();
        t_mask();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule